// File: doc/BRIEF.md
# Video Sync Stability Monitor

This block decides whether the incoming video timing is trustworthy enough to let a panel power controller switch a display on, and whether it stays so afterwards. It runs on a free-running reference clock. It receives HSYNC and VSYNC levels that are already synchronised to that clock, a toggle signal from the pixel clock domain, and a PLL lock flag. From these it derives one `timing_ok_o` flag and a separate fault flag for each detector.

Four checks run in parallel.

- **Line count.** The number of HSYNC pulses in each frame is counted, with a frame bounded by rising VSYNC edges. The count must repeat over several frames in a row.
- **VSYNC timeout.** VSYNC is declared missing when it stays away for twice the last measured frame length.
- **HSYNC timeout.** HSYNC is declared missing after a fixed gap measured in reference cycles, 32 µs at the target reference frequency.
- **Clock and lock.** The pixel clock is declared dead when its toggle stops changing. A dropped PLL lock is also a fault.

The sync group, the clock check and the PLL check can each be defeated on their own. Any fault throws away the line-count history, so the good flag only comes back after a fresh run of matching frames.

Top module: `sync_guard`

## Requirements
- R1: The line count is reported stable (`lines_unstable_o` = 0) only when the last FRAMES (default 3) per-frame HSYNC rising-edge counts are equal. A frame runs from one rising VSYNC edge to the next. An HSYNC edge that arrives in the same cycle as the VSYNC edge belongs to the new frame.
- R2: The per-frame line counter saturates at 2^LINE_W−1. A frame whose count is the saturated value never counts as stable, even when consecutive frames are equal.
- R3: `fault_hs_o` rises once HS_TMO_CYC reference cycles have elapsed without an HSYNC rising edge. A new rising edge clears it in the following cycle.
- R4: `fault_vs_o` rises when no rising VSYNC edge has been seen for twice the last measured frame length in reference cycles. Before any frame length has been measured, the limit is MAX_FRAME_CYC cycles after reset.
- R5: `fault_pll_o` is high while `pll_lock_i` is low.
- R6: `fault_clk_o` rises when the pixel-clock toggle input has not changed for CLK_TMO_CYC reference cycles. This is counted after a two-stage synchroniser.
- R7: `timing_ok_o` is high exactly when none of the five reported fault flags is high.
- R8: Defeat behaviour:
  - `bypass_pll_i` forces `fault_pll_o` low.
  - `bypass_clk_i` forces `fault_clk_o` low.
  - `bypass_sync_i` forces `fault_hs_o`, `fault_vs_o` and `lines_unstable_o` low.
  - A defeated detector neither blocks `timing_ok_o` nor clears the line history.
- R9: While any reported PLL, clock, HSYNC or VSYNC fault is high, the line history is emptied. `timing_ok_o` then stays low until FRAMES new matching frames have been counted.
- R10: After reset, `timing_ok_o` is 0, `lines_unstable_o` is 1 and the timeout fault flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_i | input | 1 | HSYNC level, synchronised to clk_ref, active high |
| vs_i | input | 1 | VSYNC level, synchronised to clk_ref, active high |
| pclk_tog_i | input | 1 | Toggle flop output from the pixel clock domain |
| pll_lock_i | input | 1 | PLL lock flag |
| bypass_pll_i | input | 1 | Defeat the PLL lock check |
| bypass_sync_i | input | 1 | Defeat the HSYNC, VSYNC and line-count checks |
| bypass_clk_i | input | 1 | Defeat the pixel clock check |
| timing_ok_o | output | 1 | All enabled checks pass |
| lines_unstable_o | output | 1 | Line count not yet stable over FRAMES frames |
| fault_vs_o | output | 1 | VSYNC missing |
| fault_hs_o | output | 1 | HSYNC missing |
| fault_clk_o | output | 1 | Pixel clock missing |
| fault_pll_o | output | 1 | PLL lock lost |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value |
|---|---|
| HS_TMO_CYC | 40 |
| LINE_W | 4 |
| FRM_W | 12 |
| MAX_FRAME_CYC | 1500 |
| CLK_TMO_CYC | 64 (default) |
| FRAMES | 3 (default) |

The narrow line counter lets a 20-line frame reach saturation. The short frame fallback lets the VSYNC limit before the first measured frame be hit within a couple of thousand cycles. With frames of 60 to 200 cycles, adaptive VSYNC limits, recovery after a fault and every defeat combination all fit in a short run. The exact cycle at which each timeout fires can be bracketed on both sides.

// File: rtl/sg_pkg.sv
package sg_pkg;
   // one bit per detector, reported after defeat masking
   typedef struct packed {
      logic lines;
      logic vs;
      logic hs;
      logic clk;
      logic pll;
   } sg_fault_t;
endpackage

// File: rtl/sg_gap_timer.sv
// Saturating counter of cycles since the last event; flags a gap at LIMIT.
module sg_gap_timer #(
   parameter int unsigned LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   output logic missing_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("sg_gap_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    gap_q <= '0;
      else if (event_i)              gap_q <= '0;
      else if (gap_q != CW'(LIMIT))  gap_q <= gap_q + 1'b1;
   end

   assign missing_o = (gap_q == CW'(LIMIT));

   // R3 / R6: an event always restarts the gap window
   a_r3_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
      event_i |=> !missing_o);
endmodule

// File: rtl/sg_vs_watch.sv
// VSYNC watchdog: limit is twice the last frame length, or a fixed fallback.
module sg_vs_watch #(
   parameter int unsigned FRM_W         = 24,
   parameter int unsigned MAX_FRAME_CYC = 4_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vs_rise_i,
   output logic missing_o
);
   localparam int unsigned SW = FRM_W + 1;

   if (MAX_FRAME_CYC >= (64'd1 << FRM_W) || MAX_FRAME_CYC < 1) begin : g_bad_frm
      $error("sg_vs_watch: MAX_FRAME_CYC must lie in 1 .. 2**FRM_W-1");
   end

   logic [SW-1:0]    since_q;
   logic [FRM_W-1:0] last_len_q;
   logic             have_len_q;
   logic [FRM_W-1:0] len_now;
   logic [SW-1:0]    limit;

   // frame length ending now, clamped to the fallback maximum
   always_comb begin
      if (since_q >= SW'(MAX_FRAME_CYC)) len_now = FRM_W'(MAX_FRAME_CYC);
      else                               len_now = since_q[FRM_W-1:0] + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q    <= '0;
         last_len_q <= '0;
         have_len_q <= 1'b0;
      end else if (vs_rise_i) begin
         since_q    <= '0;
         last_len_q <= len_now;
         have_len_q <= 1'b1;
      end else if (since_q != '1) begin
         since_q <= since_q + 1'b1;
      end
   end

   assign limit     = have_len_q ? {last_len_q, 1'b0} : SW'(MAX_FRAME_CYC);
   assign missing_o = (since_q >= limit);

   // R4: a VSYNC edge always restarts the window
   a_r4_vs_clears: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise_i |=> !missing_o);
endmodule

// File: rtl/sg_line_qual.sv
// Per-frame HSYNC counter with a history of FRAMES counts that must agree.
module sg_line_qual #(
   parameter int unsigned LINE_W = 12,
   parameter int unsigned FRAMES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_rise_i,
   input  logic vs_rise_i,
   input  logic flush_i,
   output logic stable_o
);
   localparam int unsigned NW = $clog2(FRAMES + 1);

   if (FRAMES < 2)  begin : g_bad_frames $error("sg_line_qual: FRAMES must be >= 2"); end
   if (LINE_W < 2)  begin : g_bad_width  $error("sg_line_qual: LINE_W must be >= 2"); end

   logic [LINE_W-1:0] cnt_q;
   logic [LINE_W-1:0] hist_q [FRAMES];
   logic [NW-1:0]     nfr_q;
   logic [FRAMES-1:1] eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         nfr_q <= '0;
         for (int i = 0; i < FRAMES; i++) hist_q[i] <= '0;
      end else begin
         if (vs_rise_i) begin
            cnt_q     <= hs_rise_i ? LINE_W'(1) : '0;
            hist_q[0] <= cnt_q;
            for (int i = 1; i < FRAMES; i++) hist_q[i] <= hist_q[i-1];
            if (nfr_q != NW'(FRAMES)) nfr_q <= nfr_q + 1'b1;
         end else if (hs_rise_i && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (flush_i) nfr_q <= '0;
      end
   end

   for (genvar g = 1; g < FRAMES; g++) begin : g_cmp
      assign eq[g] = (hist_q[g] == hist_q[0]);
   end

   assign stable_o = (nfr_q == NW'(FRAMES)) && (&eq) && (hist_q[0] != '1);

   // R9: a flush removes stability on the next cycle
   a_r9_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !stable_o);
   // R1: stability can only appear right after a frame boundary
   a_r1_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable_o) |-> $past(vs_rise_i));
endmodule

// File: rtl/sync_guard.sv
module sync_guard
   import sg_pkg::*;
#(
   parameter int unsigned HS_TMO_CYC    = 3200,
   parameter int unsigned CLK_TMO_CYC   = 64,
   parameter int unsigned LINE_W        = 12,
   parameter int unsigned FRAMES        = 3,
   parameter int unsigned FRM_W         = 24,
   parameter int unsigned MAX_FRAME_CYC = 4_000_000
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic hs_i,
   input  logic vs_i,
   input  logic pclk_tog_i,
   input  logic pll_lock_i,
   input  logic bypass_pll_i,
   input  logic bypass_sync_i,
   input  logic bypass_clk_i,
   output logic timing_ok_o,
   output logic lines_unstable_o,
   output logic fault_vs_o,
   output logic fault_hs_o,
   output logic fault_clk_o,
   output logic fault_pll_o
);
   logic       hs_q, vs_q;
   logic [2:0] tog_s;
   logic       hs_rise, vs_rise, tog_evt;
   logic       hs_miss, vs_miss, clk_miss, lines_ok;
   sg_fault_t  flt;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         hs_q  <= 1'b0;
         vs_q  <= 1'b0;
         tog_s <= '0;
      end else begin
         hs_q  <= hs_i;
         vs_q  <= vs_i;
         tog_s <= {tog_s[1:0], pclk_tog_i};
      end
   end

   assign hs_rise = hs_i & ~hs_q;
   assign vs_rise = vs_i & ~vs_q;
   assign tog_evt = tog_s[2] ^ tog_s[1];

   sg_gap_timer #(.LIMIT(HS_TMO_CYC)) u_hs_gap (
      .clk(clk_ref), .rst_n(rst_n), .event_i(hs_rise), .missing_o(hs_miss));

   sg_gap_timer #(.LIMIT(CLK_TMO_CYC)) u_clk_gap (
      .clk(clk_ref), .rst_n(rst_n), .event_i(tog_evt), .missing_o(clk_miss));

   sg_vs_watch #(.FRM_W(FRM_W), .MAX_FRAME_CYC(MAX_FRAME_CYC)) u_vs (
      .clk(clk_ref), .rst_n(rst_n), .vs_rise_i(vs_rise), .missing_o(vs_miss));

   sg_line_qual #(.LINE_W(LINE_W), .FRAMES(FRAMES)) u_lines (
      .clk(clk_ref), .rst_n(rst_n), .hs_rise_i(hs_rise), .vs_rise_i(vs_rise),
      .flush_i(flt.pll | flt.clk | flt.hs | flt.vs), .stable_o(lines_ok));

   always_comb begin
      flt.pll   = ~pll_lock_i & ~bypass_pll_i;
      flt.clk   = clk_miss    & ~bypass_clk_i;
      flt.hs    = hs_miss     & ~bypass_sync_i;
      flt.vs    = vs_miss     & ~bypass_sync_i;
      flt.lines = ~lines_ok   & ~bypass_sync_i;
   end

   assign timing_ok_o      = ~(|flt);
   assign lines_unstable_o = flt.lines;
   assign fault_vs_o       = flt.vs;
   assign fault_hs_o       = flt.hs;
   assign fault_clk_o      = flt.clk;
   assign fault_pll_o      = flt.pll;

   // R5: an undefeated lock loss always blocks the good flag
   a_r5_pll_blocks: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!pll_lock_i && !bypass_pll_i) |-> !timing_ok_o);
endmodule

// File: tb/sync_guard_tb.sv
module sync_guard_tb;
   localparam int HS_TMO = 40;
   localparam int MAXF   = 1500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic gen_on = 1'b0;
   logic gen_hs = 1'b0, gen_vs = 1'b0, gen_tog = 1'b0;
   logic man_hs = 1'b0, man_vs = 1'b0, man_tog = 1'b0;
   logic hs_en = 1'b1, vs_en = 1'b1, ck_en = 1'b1;
   int   lines = 8;
   logic pll = 1'b1, bpll = 1'b0, bsync = 1'b0, bclk = 1'b0;

   logic ok, un, fvs, fhs, fclk, fpll;

   sync_guard #(.HS_TMO_CYC(HS_TMO), .CLK_TMO_CYC(64), .LINE_W(4), .FRAMES(3),
                .FRM_W(12), .MAX_FRAME_CYC(MAXF)) u_dut (
      .clk_ref(clk), .rst_n(rst_n),
      .hs_i(gen_on ? gen_hs : man_hs), .vs_i(gen_on ? gen_vs : man_vs),
      .pclk_tog_i(gen_on ? gen_tog : man_tog), .pll_lock_i(pll),
      .bypass_pll_i(bpll), .bypass_sync_i(bsync), .bypass_clk_i(bclk),
      .timing_ok_o(ok), .lines_unstable_o(un), .fault_vs_o(fvs),
      .fault_hs_o(fhs), .fault_clk_o(fclk), .fault_pll_o(fpll));

   int n_chk = 0, n_bad = 0;

   task automatic chk(input logic [5:0] act, input logic [5:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // video generator: 10-cycle lines, HSYNC high 2 cycles, VSYNC high 3 cycles
   initial forever begin
      if (!gen_on) @(negedge clk);
      else begin
         int nl;
         nl = lines;
         for (int ln = 0; ln < nl; ln++)
            for (int c = 0; c < 10; c++) begin
               @(negedge clk);
               gen_hs = hs_en && (c < 2);
               gen_vs = vs_en && (ln == 0) && (c < 3);
            end
      end
   end

   initial forever begin
      repeat (3) @(negedge clk);
      if (ck_en) gen_tog = ~gen_tog;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   // vector: [17:13] lines, 12 pll, 11 hs_en, 10 vs_en, 9 ck_en, 8 bpll, 7 bsync,
   //         6 bclk, 5 exp ok, [4:0] exp {unstable, vs, hs, clk, pll}
   localparam int NV = 11;
   localparam logic [17:0] VEC [NV] = '{
      {5'd8,  4'b1111, 3'b000, 1'b1, 5'b00000},
      {5'd8,  4'b0111, 3'b000, 1'b0, 5'b10001},
      {5'd8,  4'b0111, 3'b100, 1'b1, 5'b00000},
      {5'd6,  4'b1111, 3'b000, 1'b1, 5'b00000},
      {5'd6,  4'b1110, 3'b000, 1'b0, 5'b10010},
      {5'd6,  4'b1110, 3'b001, 1'b1, 5'b00000},
      {5'd6,  4'b1011, 3'b000, 1'b0, 5'b10100},
      {5'd6,  4'b1011, 3'b010, 1'b1, 5'b00000},
      {5'd6,  4'b1101, 3'b000, 1'b0, 5'b11000},
      {5'd20, 4'b1111, 3'b000, 1'b0, 5'b10000},
      {5'd8,  4'b1111, 3'b000, 1'b1, 5'b00000}
   };

   function automatic string vtag(input int i);
      case (i)
         0, 3, 10: return "R1 R7 steady frames";
         1:        return "R5 lock lost";
         2, 5, 7:  return "R8 detector defeated";
         4:        return "R6 pixel clock stopped";
         6:        return "R3 hsync stopped";
         8:        return "R4 vsync stopped";
         default:  return "R2 saturated count";
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk({ok, un, fvs, fhs, fclk, fpll}, 6'b010000, "R10 reset state");
      rst_n = 1'b1;
      chk({ok, un, fvs, fhs, fclk, fpll}, 6'b010000, "R10 after release");

      // R4 fallback limit before any frame measured
      repeat (MAXF - 10) @(posedge clk);
      @(negedge clk);
      chk({5'b0, fvs}, 6'd0, "R4 before fallback limit");
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk({5'b0, fvs}, 6'd1, "R4 fallback limit reached");

      // R3 HSYNC gap boundary
      man_hs = 1'b1;
      @(posedge clk);
      @(negedge clk);
      man_hs = 1'b0;
      repeat (HS_TMO - 2) @(posedge clk);
      @(negedge clk);
      chk({5'b0, fhs}, 6'd0, "R3 just before hsync timeout");
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk({5'b0, fhs}, 6'd1, "R3 hsync timeout");

      // R6 clock toggle gap boundary
      man_tog = ~man_tog;
      repeat (60) @(posedge clk);
      @(negedge clk);
      chk({5'b0, fclk}, 6'd0, "R6 before clock timeout");
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk({5'b0, fclk}, 6'd1, "R6 clock timeout");

      // R4 adaptive limit: frames of 100 cycles -> limit 200
      for (int p = 0; p < 3; p++) begin
         @(negedge clk);
         man_vs = 1'b1;
         repeat (3) @(negedge clk);
         man_vs = 1'b0;
         repeat (96) @(negedge clk);
      end
      @(negedge clk);
      man_vs = 1'b1;
      repeat (3) @(negedge clk);
      man_vs = 1'b0;
      repeat (188) @(posedge clk);
      @(negedge clk);
      chk({5'b0, fvs}, 6'd0, "R4 before twice frame length");
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk({5'b0, fvs}, 6'd1, "R4 twice frame length exceeded");

      // vector table
      gen_on = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         lines = int'(VEC[i][17:13]);
         pll   = VEC[i][12];
         hs_en = VEC[i][11];
         vs_en = VEC[i][10];
         ck_en = VEC[i][9];
         bpll  = VEC[i][8];
         bsync = VEC[i][7];
         bclk  = VEC[i][6];
         repeat (1000) @(posedge clk);
         @(negedge clk);
         chk({ok, un, fvs, fhs, fclk, fpll}, {VEC[i][5], VEC[i][4:0]}, vtag(i));
      end

      // R9 recovery after a transient lock loss
      @(negedge clk);
      pll = 1'b0;
      repeat (200) @(posedge clk);
      @(negedge clk);
      pll = 1'b1;
      repeat (80) @(posedge clk);
      @(negedge clk);
      chk({ok, 5'b0}, 6'd0, "R9 good held low one frame after fault");
      repeat (800) @(posedge clk);
      @(negedge clk);
      chk({ok, un, 4'b0}, 6'b100000, "R9 good back after fresh frames");

      finish_run();
   end
endmodule